// File: doc/BRIEF.md
# Synthesizer Programming Register Interface

This block is the control-register front end of an integer-N frequency synthesizer. It produces the reference divider value, the main divider value, the swallow count and the prescaler bypass bit. It also produces five control bits for the rest of the synthesizer. Settings arrive in one of three ways:

- a serial shift port with a shift clock, a data line and a load strobe;
- an 8-bit bus with three section write strobes;
- directly from hardwired pins.

Two mode pins choose the way in use.

Written settings land in a primary word, which can be copied into a secondary word. A select input picks which of the two drives the divider outputs, so software can prepare the next channel while the current one is running, then switch over at once. A separate control register is loaded from the bus, or shifted in serially into a staging copy. In the serial case it takes effect only when its write strobe falls.

Every strobe and level input is slow and asynchronous to the system clock. Each one passes through a two-stage synchronizer. Every action happens on an edge found in the synchronized signal.

Top module: `synth_prog_if`

## Requirements
- R1: While reset is low, and directly after it, every divider output and every control output is zero. Reset clears the primary word, the secondary word and the control register.
- R2: The mode is decoded as follows. `mode_pin_dir`=1 selects pin mode whatever `mode_pin_ser` is. Otherwise `mode_pin_ser`=1 selects serial mode and `mode_pin_ser`=0 selects bus mode. Bus section strobes have no effect outside bus mode.
- R3: In serial mode, each rising `ser_clk_in` with `ser_ld_in` low and `enh_wr_in` low shifts `ser_dat_in` into the primary word. The word fills most significant bit first. The 20 bits, first in to last in, are: ref[5], ref[4], main[8], main[7], bypass, main[6:0], ref[3:0], swallow[3:0].
- R4: In serial mode, a rising `ser_ld_in` copies the primary word into the secondary word. The secondary word is not changed while bits are being shifted.
- R5: In bus mode the three section strobes load parts of the primary word:
  - a rising `bus_wr_hi` loads `bus_d[3:0]` into {ref[5], ref[4], main[8], main[7]};
  - a rising `bus_wr_mid` loads `bus_d[7]` into bypass and `bus_d[6:0]` into main[6:0];
  - a rising `bus_wr_lo` loads `bus_d[7:4]` into ref[3:0] and `bus_d[3:0]` into swallow[3:0].
- R6: In serial or bus mode, a rising `copy_in` copies the primary word into the secondary word.
- R7: The divider outputs show the primary word when the mode's select input is 1, and the secondary word when it is 0. Serial mode uses `sel_ser_in` and bus mode uses `sel_par_in`.
- R8: In pin mode the outputs follow the pins as follows, and every write strobe and copy strobe is ignored:
  - `cnt_r` = {2'b00, `pin_r`};
  - `cnt_m` = {2'b00, `pin_m`};
  - `cnt_a` = `pin_a`;
  - `psc_byp` = `pin_byp`.
- R9: In bus mode, a rising `enh_wr_in` loads the control register from `bus_d[4:0]`. The bit meanings are: bit 4 power-down, bit 3 continuous counter load, bit 2 modulus monitor, bit 1 prescaler monitor, bit 0 monitor-output disable. `bus_d[7:5]` are reserved.
- R10: In serial mode, each rising `ser_clk_in` with `enh_wr_in` high and `ser_ld_in` low shifts a control bit in, most significant first. The 8 bits are D7 to D0, with the meanings of R9. The control outputs change only on the falling edge of `enh_wr_in`, and these shifts leave the primary word alone.
- R11: The five control outputs are active only while `enh_gate_n` is low. While it is high they are all 0.
- R12: An action runs once for each rising edge of a strobe, however long the strobe stays high. Its result is visible at the outputs after the third rising clock edge following the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pin_dir | input | 1 | 1 selects pin mode |
| mode_pin_ser | input | 1 | Serial (1) or bus (0) mode when not in pin mode |
| ser_clk_in | input | 1 | Serial shift clock |
| ser_dat_in | input | 1 | Serial data, most significant bit first |
| ser_ld_in | input | 1 | Serial load strobe: low enables shifting, a rising edge copies primary to secondary |
| enh_wr_in | input | 1 | Control-register write strobe / serial target select |
| bus_d | input | 8 | Bus write data |
| bus_wr_hi | input | 1 | Bus strobe for the upper ref/main section |
| bus_wr_mid | input | 1 | Bus strobe for the bypass and main[6:0] section |
| bus_wr_lo | input | 1 | Bus strobe for the ref[3:0] and swallow section |
| copy_in | input | 1 | Primary-to-secondary copy strobe |
| sel_ser_in | input | 1 | Serial mode source select (1 primary, 0 secondary) |
| sel_par_in | input | 1 | Bus mode source select (1 primary, 0 secondary) |
| pin_r | input | 4 | Pin-mode reference divider value |
| pin_m | input | 7 | Pin-mode main divider value |
| pin_a | input | 4 | Pin-mode swallow count |
| pin_byp | input | 1 | Pin-mode prescaler bypass |
| enh_gate_n | input | 1 | Low enables the control outputs |
| cnt_r | output | 6 | Reference divider value |
| cnt_m | output | 9 | Main divider value |
| cnt_a | output | 4 | Swallow count |
| psc_byp | output | 1 | Prescaler bypass |
| ctl_pdown | output | 1 | Power-down control |
| ctl_load | output | 1 | Continuous counter load control |
| ctl_msel_mon | output | 1 | Modulus-select monitor enable |
| ctl_psc_mon | output | 1 | Prescaler monitor enable |
| ctl_out_off | output | 1 | Monitor outputs disable |

## Verification
The word path is driven three ways:

- Bus section writes use data whose nibbles differ. A mapping that swaps sections or bit order then shows up in the decoded fields.
- A serial word has its top four bits mixed. This separates a correct MSB-first shift from a reversed or misaligned one.
- A second serial word holds only the swallow field. This confirms a plain copy strobe on its own.

Each load is followed by toggling the select inputs before and after the copy strobes, which tells primary from secondary. Writes are also issued in the wrong mode, in pin mode and in serial mode, to show they are ignored. Control bits are shifted with an uneven pattern and checked while the enable is still high, which tells a commit on the falling edge from an early one. One strobe is held high while its data changes, and its result is timed cycle by cycle, which pins down both edge detection and the three-cycle latency.

// File: rtl/synth_prog_pkg.sv
// Shared widths, strobe indices, mode type and word decode for the
// synthesizer programming interface. The 20-bit word layout is fixed by the
// serial shift order: bit 19 is shifted in first.
package synth_prog_pkg;

    localparam int R_W     = 6;                      // reference divider width
    localparam int M_W     = 9;                      // main divider width
    localparam int A_W     = 4;                      // swallow count width
    localparam int R_LO_W  = 4;                      // pin-mode reference bits
    localparam int M_LO_W  = 7;                      // pin-mode main bits
    localparam int BUS_W   = 8;                      // bus data width
    localparam int CTL_W   = 5;                      // meaningful control bits
    localparam int ENH_LEN = 8;                      // serial control frame length
    localparam int WORD_W  = R_W + M_W + A_W + 1;    // 20-bit settings word

    // Section boundaries inside the word (bus sections).
    localparam int SEC_HI_LSB  = WORD_W - 4;         // {r5,r4,m8,m7}
    localparam int SEC_MID_LSB = SEC_HI_LSB - BUS_W; // {byp,m6..m0}
    localparam int SEC_LO_LSB  = 0;                  // {r3..r0,a3..a0}

    // Strobe vector indices.
    localparam int ST_SCK = 0;
    localparam int ST_LD  = 1;
    localparam int ST_EWR = 2;
    localparam int ST_HI  = 3;
    localparam int ST_MID = 4;
    localparam int ST_LO  = 5;
    localparam int ST_CPY = 6;
    localparam int ST_N   = 7;

    typedef enum logic [1:0] {
        IFM_BUS   = 2'd0,
        IFM_SHIFT = 2'd1,
        IFM_PINS  = 2'd2
    } if_mode_t;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic           byp;
    } cnt_set_t;

    // Split a settings word into its divider fields.
    function automatic cnt_set_t unpack_word(input logic [WORD_W-1:0] w);
        cnt_set_t s;
        s.r   = {w[WORD_W-1:WORD_W-2], w[2*A_W-1:A_W]};
        s.m   = {w[WORD_W-3:WORD_W-4], w[SEC_MID_LSB+M_LO_W-1:SEC_MID_LSB]};
        s.a   = w[A_W-1:0];
        s.byp = w[SEC_MID_LSB+M_LO_W];
        return s;
    endfunction

endpackage

// File: rtl/sp_sync.sv
// Multi-stage synchronizer for a vector of slow asynchronous inputs.
// Assumes each bit changes far slower than clk; bits are not treated as a
// coherent bus, so data must be held stable around its strobe.
module sp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain;

    // Stage registers, first stage captures the raw input.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                // Pass the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/sp_edge_det.sv
// Rising-edge detector on a synchronized strobe vector, plus a falling-edge
// detector on one chosen bit. Pulses last exactly one clock.
module sp_edge_det #(
    parameter int W        = 1,
    parameter int FALL_IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic         fall_one
);

    logic [W-1:0] prev;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise     = lvl & ~prev;
    assign fall_one = prev[FALL_IDX] & ~lvl[FALL_IDX];

endmodule

// File: rtl/sp_word_regs.sv
// Primary and secondary settings words. The primary is written by the serial
// shift or by the three bus sections (mutually exclusive by mode); the
// secondary copies the pre-update primary on a copy request.
module sp_word_regs import synth_prog_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              wr_hi,
    input  logic              wr_mid,
    input  logic              wr_lo,
    input  logic [BUS_W-1:0]  bus_val,
    input  logic              copy_en,
    output logic [WORD_W-1:0] prim_q,
    output logic [WORD_W-1:0] sec_q
);

    localparam int HI_W = WORD_W - SEC_HI_LSB;

    // Primary word: serial shift or bus section loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q <= '0;
        end else if (shift_en) begin
            prim_q <= {prim_q[WORD_W-2:0], shift_bit};
        end else begin
            if (wr_hi)  prim_q[WORD_W-1:SEC_HI_LSB] <= bus_val[HI_W-1:0];
            if (wr_mid) prim_q[SEC_HI_LSB-1:SEC_MID_LSB] <= bus_val;
            if (wr_lo)  prim_q[SEC_MID_LSB-1:SEC_LO_LSB] <= bus_val;
        end
    end

    // Secondary word: copy of the primary.
    always_ff @(posedge clk) begin
        if (!rst_n)       sec_q <= '0;
        else if (copy_en) sec_q <= prim_q;
    end

endmodule

// File: rtl/sp_enh_regs.sv
// Control register with a serial staging copy. Only the low CTL_W bits of a
// serial frame survive in staging; the reserved leading bits shift out.
module sp_enh_regs import synth_prog_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             commit_en,
    input  logic             load_en,
    input  logic [CTL_W-1:0] load_val,
    output logic [CTL_W-1:0] act_q
);

    logic [CTL_W-1:0] stage_q;

    // Serial staging shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (shift_en) stage_q <= {stage_q[CTL_W-2:0], shift_bit};
    end

    // Active control bits: bus load, or commit of staged bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_q <= '0;
        else if (load_en)   act_q <= load_val;
        else if (commit_en) act_q <= stage_q;
    end

endmodule

// File: rtl/synth_prog_if.sv
// Synthesizer programming register interface (top). Synchronizes all pins,
// detects strobe edges, decodes the interface mode, steers writes into the
// word and control registers and selects the divider source.
// Assumes strobes and data are held for at least three clocks.
module synth_prog_if import synth_prog_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin_dir,
    input  logic              mode_pin_ser,
    input  logic              ser_clk_in,
    input  logic              ser_dat_in,
    input  logic              ser_ld_in,
    input  logic              enh_wr_in,
    input  logic [BUS_W-1:0]  bus_d,
    input  logic              bus_wr_hi,
    input  logic              bus_wr_mid,
    input  logic              bus_wr_lo,
    input  logic              copy_in,
    input  logic              sel_ser_in,
    input  logic              sel_par_in,
    input  logic [R_LO_W-1:0] pin_r,
    input  logic [M_LO_W-1:0] pin_m,
    input  logic [A_W-1:0]    pin_a,
    input  logic              pin_byp,
    input  logic              enh_gate_n,
    output logic [R_W-1:0]    cnt_r,
    output logic [M_W-1:0]    cnt_m,
    output logic [A_W-1:0]    cnt_a,
    output logic              psc_byp,
    output logic              ctl_pdown,
    output logic              ctl_load,
    output logic              ctl_msel_mon,
    output logic              ctl_psc_mon,
    output logic              ctl_out_off
);

    localparam int LVL_W = 6 + BUS_W + R_LO_W + M_LO_W + A_W + 1;

    // ---- level inputs ----
    logic [LVL_W-1:0]  lvl_raw, lvl_s;
    logic              mode_dir_s, mode_ser_s, dat_s, sel_ser_s, sel_par_s, gate_n_s;
    logic [BUS_W-1:0]  bus_s;
    logic [R_LO_W-1:0] pin_r_s;
    logic [M_LO_W-1:0] pin_m_s;
    logic [A_W-1:0]    pin_a_s;
    logic              pin_byp_s;

    assign lvl_raw = {mode_pin_dir, mode_pin_ser, ser_dat_in, sel_ser_in, sel_par_in,
                      enh_gate_n, bus_d, pin_r, pin_m, pin_a, pin_byp};

    sp_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_lvl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lvl_raw),
        .dout (lvl_s)
    );

    assign {mode_dir_s, mode_ser_s, dat_s, sel_ser_s, sel_par_s,
            gate_n_s, bus_s, pin_r_s, pin_m_s, pin_a_s, pin_byp_s} = lvl_s;

    // ---- strobes ----
    logic [ST_N-1:0] st_raw, st_s, st_rise;
    logic            enh_fall;

    assign st_raw[ST_SCK] = ser_clk_in;
    assign st_raw[ST_LD]  = ser_ld_in;
    assign st_raw[ST_EWR] = enh_wr_in;
    assign st_raw[ST_HI]  = bus_wr_hi;
    assign st_raw[ST_MID] = bus_wr_mid;
    assign st_raw[ST_LO]  = bus_wr_lo;
    assign st_raw[ST_CPY] = copy_in;

    sp_sync #(.W(ST_N), .STAGES(SYNC_STAGES)) u_st_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (st_raw),
        .dout (st_s)
    );

    sp_edge_det #(.W(ST_N), .FALL_IDX(ST_EWR)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (st_s),
        .rise    (st_rise),
        .fall_one(enh_fall)
    );

    // ---- mode decode ----
    if_mode_t mode;
    logic     in_ser, in_bus;

    // Pin mode wins; otherwise the serial pin picks serial or bus.
    always_comb begin
        if (mode_dir_s)      mode = IFM_PINS;
        else if (mode_ser_s) mode = IFM_SHIFT;
        else                 mode = IFM_BUS;
    end

    assign in_ser = (mode == IFM_SHIFT);
    assign in_bus = (mode == IFM_BUS);

    // ---- write events ----
    logic ser_tick, shift_prim, shift_enh, wr_hi, wr_mid, wr_lo;
    logic copy_ev, enh_load, enh_commit, prim_we, enh_ev;

    assign ser_tick   = in_ser & st_rise[ST_SCK] & ~st_s[ST_LD];
    assign shift_prim = ser_tick & ~st_s[ST_EWR];
    assign shift_enh  = ser_tick &  st_s[ST_EWR];
    assign wr_hi      = in_bus & st_rise[ST_HI];
    assign wr_mid     = in_bus & st_rise[ST_MID];
    assign wr_lo      = in_bus & st_rise[ST_LO];
    assign copy_ev    = (in_ser & st_rise[ST_LD]) | ((in_ser | in_bus) & st_rise[ST_CPY]);
    assign enh_load   = in_bus & st_rise[ST_EWR];
    assign enh_commit = in_ser & enh_fall;
    assign prim_we    = shift_prim | wr_hi | wr_mid | wr_lo;
    assign enh_ev     = enh_load | enh_commit;

    // ---- storage ----
    logic [WORD_W-1:0] prim_q, sec_q;
    logic [CTL_W-1:0]  enh_act;

    sp_word_regs u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_prim),
        .shift_bit(dat_s),
        .wr_hi    (wr_hi),
        .wr_mid   (wr_mid),
        .wr_lo    (wr_lo),
        .bus_val  (bus_s),
        .copy_en  (copy_ev),
        .prim_q   (prim_q),
        .sec_q    (sec_q)
    );

    sp_enh_regs u_enh (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_enh),
        .shift_bit(dat_s),
        .commit_en(enh_commit),
        .load_en  (enh_load),
        .load_val (bus_s[CTL_W-1:0]),
        .act_q    (enh_act)
    );

    // ---- output selection ----
    cnt_set_t live;
    logic     pick_prim;

    // Choose primary/secondary, or the pins in pin mode.
    always_comb begin
        pick_prim = in_ser ? sel_ser_s : sel_par_s;
        live      = unpack_word(pick_prim ? prim_q : sec_q);
        if (mode == IFM_PINS) begin
            live.r   = R_W'(pin_r_s);
            live.m   = M_W'(pin_m_s);
            live.a   = pin_a_s;
            live.byp = pin_byp_s;
        end
    end

    assign cnt_r   = live.r;
    assign cnt_m   = live.m;
    assign cnt_a   = live.a;
    assign psc_byp = live.byp;

    assign {ctl_pdown, ctl_load, ctl_msel_mon, ctl_psc_mon, ctl_out_off} =
        gate_n_s ? {CTL_W{1'b0}} : enh_act;

endmodule

// File: rtl/synth_prog_chk.sv
// Property checker for synth_prog_if, attached by bind. Observes the write
// events, the stored words and the divider outputs.
module synth_prog_chk import synth_prog_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] prim,
    input logic [WORD_W-1:0] sec,
    input logic [CTL_W-1:0]  enh,
    input logic              prim_we,
    input logic              copy_ev,
    input logic              enh_ev,
    input logic              dir_mode,
    input logic [R_W-1:0]    cnt_r,
    input logic [M_W-1:0]    cnt_m
);

    assert_prim_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !prim_we |=> $stable(prim));

    assert_copy_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        copy_ev |=> (sec == $past(prim)));

    assert_sec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_ev |=> $stable(sec));

    assert_pins_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_mode |-> (cnt_r[R_W-1:R_LO_W] == '0 && cnt_m[M_W-1:M_LO_W] == '0));

    assert_pins_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_mode |-> !(prim_we || copy_ev || enh_ev));

    assert_enh_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_ev |=> $stable(enh));

    assert_copy_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        copy_ev |=> !copy_ev);

endmodule

bind synth_prog_if synth_prog_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .prim    (prim_q),
    .sec     (sec_q),
    .enh     (enh_act),
    .prim_we (prim_we),
    .copy_ev (copy_ev),
    .enh_ev  (enh_ev),
    .dir_mode(mode_dir_s),
    .cnt_r   (cnt_r),
    .cnt_m   (cnt_m)
);

// File: tb/tb_synth_prog_if.sv
`timescale 1ns/1ps
module tb_synth_prog_if;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_pin_dir = 0, mode_pin_ser = 0, ser_clk_in = 0, ser_dat_in = 0;
    logic ser_ld_in = 0, enh_wr_in = 0, bus_wr_hi = 0, bus_wr_mid = 0, bus_wr_lo = 0;
    logic copy_in = 0, sel_ser_in = 0, sel_par_in = 0, pin_byp = 0, enh_gate_n = 0;
    logic [7:0] bus_d = '0;
    logic [3:0] pin_r = '0, pin_a = '0;
    logic [6:0] pin_m = '0;
    logic [5:0] cnt_r;
    logic [8:0] cnt_m;
    logic [3:0] cnt_a;
    logic psc_byp, ctl_pdown, ctl_load, ctl_msel_mon, ctl_psc_mon, ctl_out_off;

    always #2.5 clk = ~clk;

    synth_prog_if dut (
        .clk(clk), .rst_n(rst_n), .mode_pin_dir(mode_pin_dir), .mode_pin_ser(mode_pin_ser),
        .ser_clk_in(ser_clk_in), .ser_dat_in(ser_dat_in), .ser_ld_in(ser_ld_in),
        .enh_wr_in(enh_wr_in), .bus_d(bus_d), .bus_wr_hi(bus_wr_hi), .bus_wr_mid(bus_wr_mid),
        .bus_wr_lo(bus_wr_lo), .copy_in(copy_in), .sel_ser_in(sel_ser_in),
        .sel_par_in(sel_par_in), .pin_r(pin_r), .pin_m(pin_m), .pin_a(pin_a),
        .pin_byp(pin_byp), .enh_gate_n(enh_gate_n), .cnt_r(cnt_r), .cnt_m(cnt_m),
        .cnt_a(cnt_a), .psc_byp(psc_byp), .ctl_pdown(ctl_pdown), .ctl_load(ctl_load),
        .ctl_msel_mon(ctl_msel_mon), .ctl_psc_mon(ctl_psc_mon), .ctl_out_off(ctl_out_off)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic dir, ser, sck, dat, ld, ewr, hi, mid, lo, cpy, sels, selp, gn;
        logic [7:0] d;
        logic [3:0] pr;
        logic [6:0] pm;
        logic [3:0] pa;
        logic       pb;
    } snap_t;

    snap_t       hist[$];
    logic [19:0] m_prim = '0, m_sec = '0;
    logic [7:0]  m_stg = '0;
    logic [4:0]  m_enh = '0;
    logic [24:0] exp_vec = '0;
    bit          model_ok = 0;

    function automatic snap_t take();
        snap_t s;
        s.dir = mode_pin_dir; s.ser = mode_pin_ser; s.sck = ser_clk_in; s.dat = ser_dat_in;
        s.ld = ser_ld_in; s.ewr = enh_wr_in; s.hi = bus_wr_hi; s.mid = bus_wr_mid;
        s.lo = bus_wr_lo; s.cpy = copy_in; s.sels = sel_ser_in; s.selp = sel_par_in;
        s.gn = enh_gate_n; s.d = bus_d; s.pr = pin_r; s.pm = pin_m; s.pa = pin_a; s.pb = pin_byp;
        return s;
    endfunction

    // Apply actions seen in the edge between sample q (older) and p.
    task automatic model_step(snap_t p, snap_t q);
        logic        ser_m, bus_m;
        logic [19:0] np;
        ser_m = !p.dir && p.ser;
        bus_m = !p.dir && !p.ser;
        np = m_prim;
        if (ser_m && p.sck && !q.sck && !p.ld) begin
            if (!p.ewr) np = {m_prim[18:0], p.dat};
            else        m_stg = {m_stg[6:0], p.dat};
        end
        if (ser_m && q.ewr && !p.ewr) m_enh = m_stg[4:0];
        if (bus_m) begin
            if (p.hi && !q.hi)   np[19:16] = p.d[3:0];
            if (p.mid && !q.mid) np[15:8]  = p.d;
            if (p.lo && !q.lo)   np[7:0]   = p.d;
            if (p.ewr && !q.ewr) m_enh     = p.d[4:0];
        end
        if ((ser_m && p.ld && !q.ld) || ((ser_m || bus_m) && p.cpy && !q.cpy)) m_sec = m_prim;
        m_prim = np;
    endtask

    function automatic logic [24:0] model_out(snap_t s);
        logic [19:0] w;
        logic [5:0]  r;
        logic [8:0]  m;
        logic [3:0]  a;
        logic        b;
        if (s.dir) begin
            r = {2'b00, s.pr}; m = {2'b00, s.pm}; a = s.pa; b = s.pb;
        end else begin
            w = ((s.ser ? s.sels : s.selp) != 0) ? m_prim : m_sec;
            r = {w[19], w[18], w[7], w[6], w[5], w[4]};
            m = {w[17], w[16], w[14], w[13], w[12], w[11], w[10], w[9], w[8]};
            a = w[3:0];
            b = w[15];
        end
        return {r, m, a, b, (s.gn ? 5'b0 : m_enh)};
    endfunction

    // Advance the model on every clock edge.
    always @(posedge clk) begin
        snap_t cur;
        cur = take();
        cycles++;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 4; i++) hist.push_back('0);
            m_prim = '0; m_sec = '0; m_stg = '0; m_enh = '0;
        end else begin
            hist.push_front(cur);
            void'(hist.pop_back());
            model_step(hist[2], hist[3]);
        end
        exp_vec  = model_out(hist[1]);
        model_ok = 1;
    end

    // Compare the whole output vector every clock, away from the edge.
    always @(negedge clk) begin
        logic [24:0] got;
        got = {cnt_r, cnt_m, cnt_a, psc_byp, ctl_pdown, ctl_load, ctl_msel_mon,
               ctl_psc_mon, ctl_out_off};
        if (model_ok) begin
            checks++;
            if (got !== exp_vec) begin
                errors++;
                $display("FAIL %s per-cycle: got %h expected %h at cycle %0d",
                         cur_req, got, exp_vec, cycles);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string tag, logic [31:0] got, logic [31:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(logic b);
        ser_dat_in = b; tick(1);
        ser_clk_in = 1; tick(4);
        ser_clk_in = 0; tick(4);
    endtask

    task automatic ser_word(logic [19:0] v);
        for (int i = 19; i >= 0; i--) ser_bit(v[i]);
    endtask

    // which: 0 hi, 1 mid, 2 lo, 3 control write, 4 copy
    task automatic strobe(int which, logic [7:0] d);
        bus_d = d; tick(1);
        case (which)
            0: bus_wr_hi = 1;  1: bus_wr_mid = 1; 2: bus_wr_lo = 1;
            3: enh_wr_in = 1;  default: copy_in = 1;
        endcase
        tick(4);
        bus_wr_hi = 0; bus_wr_mid = 0; bus_wr_lo = 0; enh_wr_in = 0; copy_in = 0;
        tick(4);
    endtask

    function automatic logic [4:0] ctl_now();
        return {ctl_pdown, ctl_load, ctl_msel_mon, ctl_psc_mon, ctl_out_off};
    endfunction

    // ---------------- test sequence ----------------
    initial begin
        cur_req = "R1";
        tick(5);
        chk("R1 reset cnt_m", 32'(cnt_m), 0);
        chk("R1 reset cnt_r/a/byp", 32'({cnt_r, cnt_a, psc_byp}), 0);
        chk("R1 reset ctl", 32'(ctl_now()), 0);
        rst_n = 1; tick(4);
        chk("R1 after reset", 32'({cnt_r, cnt_m, cnt_a, psc_byp, ctl_now()}), 0);

        // Bus section writes.
        cur_req = "R5"; sel_par_in = 1; tick(4);
        strobe(0, 8'hFA); strobe(1, 8'hA5); strobe(2, 8'h3C);
        chk("R5 cnt_r", 32'(cnt_r), 32'h23);
        chk("R5 cnt_m", 32'(cnt_m), 32'h125);
        chk("R5 cnt_a/byp", 32'({cnt_a, psc_byp}), 32'h19);
        cur_req = "R7"; sel_par_in = 0; tick(4);
        chk("R7 secondary selected", 32'(cnt_m), 0);
        cur_req = "R6"; strobe(4, 8'h00);
        chk("R6 copy in bus mode", 32'(cnt_m), 32'h125);

        // Serial word.
        cur_req = "R3"; mode_pin_ser = 1; sel_ser_in = 0; tick(4);
        ser_word(20'hB6D17);
        chk("R4 secondary untouched by shift", 32'(cnt_m), 32'h125);
        sel_ser_in = 1; tick(4);
        chk("R3 serial cnt_m", 32'(cnt_m), 32'h1ED);
        chk("R3 serial cnt_r", 32'(cnt_r), 32'h21);
        chk("R3 serial cnt_a/byp", 32'({cnt_a, psc_byp}), 32'hE);
        cur_req = "R4"; sel_ser_in = 0; tick(4);
        ser_ld_in = 1; tick(4); ser_ld_in = 0; tick(4);
        chk("R4 load copies", 32'(cnt_m), 32'h1ED);
        cur_req = "R2"; strobe(0, 8'h00); sel_ser_in = 1; tick(4);
        chk("R2 bus write ignored in serial", 32'(cnt_r), 32'h21);

        cur_req = "R6"; sel_ser_in = 0; tick(4);
        ser_word(20'h00005);
        strobe(4, 8'h00);
        chk("R6 copy in serial mode", 32'({cnt_m, cnt_a}), 32'h5);

        // Serial control frame.
        cur_req = "R10"; sel_ser_in = 1; enh_wr_in = 1; tick(4);
        ser_bit(1); ser_bit(1); ser_bit(1); ser_bit(0);
        chk("R10 no change mid-frame", 32'(ctl_now()), 0);
        ser_bit(1); ser_bit(0); ser_bit(1); ser_bit(0);
        chk("R10 no change before fall", 32'(ctl_now()), 0);
        chk("R10 primary untouched", 32'({cnt_r, cnt_m, cnt_a}), 32'h5);
        enh_wr_in = 0; tick(4);
        chk("R10 commit on fall", 32'(ctl_now()), 32'h0A);
        cur_req = "R11"; enh_gate_n = 1; tick(4);
        chk("R11 gated off", 32'(ctl_now()), 0);
        enh_gate_n = 0; tick(4);
        chk("R11 gate open", 32'(ctl_now()), 32'h0A);

        // Bus control write.
        cur_req = "R9"; mode_pin_ser = 0; tick(4);
        strobe(3, 8'hF1);
        chk("R9 bus control load", 32'(ctl_now()), 32'h11);

        // Pin mode.
        cur_req = "R8"; pin_r = 4'h9; pin_m = 7'h7F; pin_a = 4'h3; pin_byp = 1;
        mode_pin_dir = 1; mode_pin_ser = 1; tick(4);
        chk("R8 pins cnt_r (R2 pin mode wins)", 32'(cnt_r), 32'h09);
        chk("R8 pins cnt_m", 32'(cnt_m), 32'h07F);
        chk("R8 pins cnt_a/byp", 32'({cnt_a, psc_byp}), 32'h7);
        strobe(0, 8'h0F); strobe(1, 8'hFF); strobe(2, 8'hFF); strobe(4, 8'h00);
        mode_pin_dir = 0; mode_pin_ser = 0; sel_par_in = 1; tick(4);
        chk("R8 writes ignored (primary)", 32'({cnt_r, cnt_m, cnt_a, psc_byp}), 32'hA);
        sel_par_in = 0; tick(4);
        chk("R8 writes ignored (secondary)", 32'({cnt_r, cnt_m, cnt_a, psc_byp}), 32'hA);

        // Latency and single action per edge.
        cur_req = "R12"; sel_par_in = 1; bus_d = 8'h5A; tick(4);
        bus_wr_lo = 1; tick(2);
        chk("R12 not yet after two edges", 32'(cnt_a), 32'h5);
        tick(1);
        chk("R12 updated after third edge", 32'({cnt_r[3:0], cnt_a}), 32'h5A);
        bus_d = 8'h00; tick(6);
        chk("R12 held strobe acts once", 32'({cnt_r[3:0], cnt_a}), 32'h5A);
        bus_wr_lo = 0; tick(6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule